// File: doc/BRIEF.md
# Eight-Level Programmable Interrupt Controller

This block collects eight interrupt request lines and signals the processor when one of them needs service. It chooses one level at a time and returns an 8-bit vector for it. Software programs it through a byte-wide port with two addresses. A write at the low address with bit 4 set starts an initialization sequence. That sequence sets the trigger mode, the vector base and the end-of-interrupt style. Later writes are decoded as operation commands: the mask, end-of-interrupt and priority commands, register-read selection and poll. The decoding uses the address and the bit pattern of the written byte.

Requests are latched on rising edges, or follow the input in level mode. They pass through the mask and then a priority resolver. The resolver's order is fixed after initialization and can be rotated by command. A request interrupts only if it outranks every level currently marked in service. The processor answers with a one-cycle acknowledge pulse. In that same cycle it reads the vector, and the level moves from pending to in service. Instead of acknowledging, software may poll. A poll byte holds a pending flag in bit 7 and the winning level in bits 2:0, and the poll read services that level in the same way.

The register port is plain control access: a strobe is accepted in the cycle it is presented and is never back-pressured. Read data and the acknowledge vector are combinational, so they are valid in the cycle of the strobe.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, `int_out` is low. The mask reads 0xFF at address 1 and the request register reads 0x00 at address 0. Level 0 has the highest priority and edge triggering is selected.
- R2: A write at address 0 with bit 4 set starts initialization. Its bit 0 means a fourth word follows, bit 1 means single mode (no third word) and bit 3 selects level triggering. The next address-1 writes are then taken in order: the vector base (bits 7:3), the third word (cascade mode only, content ignored) and the fourth word (only if requested). Initialization clears the mask, the in-service register, the latched requests and any rotation, and selects the request register for reads. `int_out` stays low until the last word is written.
- R3: Once initialized, address 1 reads and writes the mask, and a set bit n keeps level n from raising `int_out`. A masked edge is still latched and still shows in the request register.
- R4: In edge mode, a 0-to-1 input change sets request bit n, which stays set after the input falls until the level is serviced. In level mode, request bit n equals input n.
- R5: `int_out` is high exactly when some unmasked pending level ranks above every in-service level. A request at or below the top in-service level waits.
- R6: In an `ack` cycle with `int_out` high, `ack_vector` is {base[7:3], level}. On the next cycle the edge request bit is clear and the in-service bit is set. An `ack` while `int_out` is low returns {base, 3'b111} and changes nothing.
- R7: A write at address 0 with bits 4:3 = 00 is a command with code bits 7:5. Code 001 clears the highest-ranked in-service bit. Code 011 clears the in-service bit named by bits 2:0.
- R8: Code 101 acts as 001 and makes the cleared level the lowest priority. Code 111 acts as 011 and makes level bits 2:0 the lowest. Code 110 only makes level bits 2:0 the lowest. Code 010 has no effect.
- R9: If fourth-word bit 1 is set, an acknowledged level is not kept in service. Code 100 turns on rotate-in-auto mode, in which each serviced level becomes the lowest priority; code 000 turns it off.
- R10: A write at address 0 with bits 4:3 = 01 whose bit 1 is set makes later address-0 reads return the in-service register (bit 0 = 1) or the request register (bit 0 = 0). With bit 1 clear the selection is kept.
- R11: Such a write with bit 2 set arms a poll. The next address-0 read returns {1, 0000, level} and services that level as an `ack` would, or returns 0x00 if nothing is eligible. That read disarms the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read strobe, else 0 |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to the processor |
| ack | input | 1 | Acknowledge pulse, one cycle |
| ack_vector | output | 8 | Vector returned during `ack` |

## Verification
The hardest state to reach is a rotated priority order combined with nested in-service levels. In that state a pending level must be held back because it now ranks below a level that ranked lower before the rotation. The bench gets there with commands only. It sets the lowest level explicitly, services one of two simultaneous edges, rotates on end-of-interrupt and services the other. It then shows that a fresh request on the just-rotated level stays blocked, and that a no-op command leaves the in-service register untouched. The same approach covers rotate-in-auto mode, where the order changes as a side effect of each acknowledge.

// File: rtl/irq_ctrl8_pkg.sv
package irq_ctrl8_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BASE  = 2'd1,
    ST_CASC  = 2'd2,
    ST_OPTS  = 2'd3
  } init_st_e;

  // command codes held in bits 7:5 of an address-0 command write
  typedef enum logic [2:0] {
    CMD_AROT_OFF = 3'b000,
    CMD_NS_EOI   = 3'b001,
    CMD_NOP      = 3'b010,
    CMD_SP_EOI   = 3'b011,
    CMD_AROT_ON  = 3'b100,
    CMD_ROT_NS   = 3'b101,
    CMD_SET_LOW  = 3'b110,
    CMD_ROT_SP   = 3'b111
  } eoi_cmd_e;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_ctrl8_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DW      = 8,
  parameter int LVL_W   = $clog2(NUM_IRQ),
  parameter int BASE_W  = DW - LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [DW-1:0]      wdata,
  input  logic               isr_any,
  input  logic [LVL_W-1:0]   isr_top,
  input  logic               svc,
  input  logic [LVL_W-1:0]   svc_lvl,
  output logic               ready,
  output logic [NUM_IRQ-1:0] mask,
  output logic [BASE_W-1:0]  vec_base,
  output logic               level_mode,
  output logic               aeoi,
  output logic               read_isr,
  output logic               poll_armed,
  output logic [LVL_W-1:0]   lowest,
  output logic               init_clr,
  output logic               eoi_clr,
  output logic [LVL_W-1:0]   eoi_lvl
);

  init_st_e   st;
  logic       single_mode;
  logic       need_opts;
  logic       rot_auto;
  logic       is_init, is_cmd, is_sel, is_hi;
  eoi_cmd_e   cmd;
  logic       rot_now;
  logic [LVL_W-1:0] rot_lvl;

  assign ready   = (st == ST_READY);
  assign is_init = wr_en && !addr && wdata[4];
  assign is_cmd  = wr_en && !addr && !wdata[4] && !wdata[3] && ready;
  assign is_sel  = wr_en && !addr && !wdata[4] &&  wdata[3] && ready;
  assign is_hi   = wr_en && addr;
  assign cmd     = eoi_cmd_e'(wdata[7:5]);
  assign init_clr = is_init;

  always_comb begin
    eoi_clr = is_cmd && wdata[5] && (wdata[6] || isr_any);
    eoi_lvl = wdata[6] ? wdata[LVL_W-1:0] : isr_top;
    rot_now = 1'b0;
    rot_lvl = wdata[LVL_W-1:0];
    if (is_cmd) begin
      case (cmd)
        CMD_ROT_NS: begin
          rot_now = isr_any;
          rot_lvl = isr_top;
        end
        CMD_ROT_SP, CMD_SET_LOW: rot_now = 1'b1;
        default: rot_now = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_READY;
      mask        <= '1;
      vec_base    <= '0;
      level_mode  <= 1'b0;
      single_mode <= 1'b0;
      need_opts   <= 1'b0;
      aeoi        <= 1'b0;
      rot_auto    <= 1'b0;
      read_isr    <= 1'b0;
      poll_armed  <= 1'b0;
      lowest      <= LVL_W'(NUM_IRQ - 1);
    end else if (is_init) begin
      st          <= ST_BASE;
      mask        <= '0;
      level_mode  <= wdata[3];
      single_mode <= wdata[1];
      need_opts   <= wdata[0];
      aeoi        <= 1'b0;
      rot_auto    <= 1'b0;
      read_isr    <= 1'b0;
      poll_armed  <= 1'b0;
      lowest      <= LVL_W'(NUM_IRQ - 1);
    end else begin
      if (is_hi) begin
        case (st)
          ST_BASE: begin
            vec_base <= wdata[DW-1:LVL_W];
            if (!single_mode)   st <= ST_CASC;
            else if (need_opts) st <= ST_OPTS;
            else                st <= ST_READY;
          end
          ST_CASC: st <= need_opts ? ST_OPTS : ST_READY;
          ST_OPTS: begin
            aeoi <= wdata[1];
            st   <= ST_READY;
          end
          default: mask <= wdata[NUM_IRQ-1:0];
        endcase
      end
      if (poll_armed && rd_en && !addr) poll_armed <= 1'b0;
      if (is_sel) begin
        if (wdata[1]) read_isr <= wdata[0];
        if (wdata[2]) poll_armed <= 1'b1;
      end
      if (is_cmd && cmd == CMD_AROT_ON)  rot_auto <= 1'b1;
      if (is_cmd && cmd == CMD_AROT_OFF) rot_auto <= 1'b0;
      if (rot_now)                         lowest <= rot_lvl;
      else if (svc && aeoi && rot_auto)    lowest <= svc_lvl;
    end
  end

endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               level_mode,
  input  logic               init_clr,
  input  logic               svc,
  input  logic [LVL_W-1:0]   svc_lvl,
  output logic [NUM_IRQ-1:0] irr
);

  logic [NUM_IRQ-1:0] prev;
  logic [NUM_IRQ-1:0] latched;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    logic hit;
    assign hit = svc && (svc_lvl == LVL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n || init_clr) begin
        prev[i]    <= 1'b1;
        latched[i] <= 1'b0;
      end else begin
        prev[i]    <= irq_in[i];
        latched[i] <= (latched[i] | (irq_in[i] & ~prev[i])) & ~hit;
      end
    end
    assign irr[i] = level_mode ? irq_in[i] : latched[i];
  end

endmodule

// File: rtl/irq_isr_reg.sv
module irq_isr_reg #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_clr,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_lvl,
  input  logic               clr_en,
  input  logic [LVL_W-1:0]   clr_lvl,
  output logic [NUM_IRQ-1:0] isr
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    logic do_set, do_clr;
    assign do_set = set_en && (set_lvl == LVL_W'(i));
    assign do_clr = clr_en && (clr_lvl == LVL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n || init_clr) isr[i] <= 1'b0;
      else if (do_set)        isr[i] <= 1'b1;
      else if (do_clr)        isr[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] isr,
  input  logic [LVL_W-1:0]   lowest,
  input  logic               ready,
  output logic [LVL_W-1:0]   req_lvl,
  output logic               isr_any,
  output logic [LVL_W-1:0]   isr_top,
  output logic               int_ok
);

  // returns {found, rank}; rank 0 is the level just above 'lo'
  function automatic logic [LVL_W:0] first_set(input logic [NUM_IRQ-1:0] v,
                                               input logic [LVL_W-1:0]   lo);
    logic [LVL_W:0] res;
    res = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (v[(int'(lo) + 1 + k) % NUM_IRQ]) res = {1'b1, LVL_W'(k)};
    end
    return res;
  endfunction

  function automatic logic [LVL_W-1:0] rank_to_lvl(input logic [LVL_W-1:0] r,
                                                   input logic [LVL_W-1:0] lo);
    return LVL_W'((int'(lo) + 1 + int'(r)) % NUM_IRQ);
  endfunction

  logic [LVL_W:0] req_hit, isr_hit;

  assign req_hit = first_set(pend, lowest);
  assign isr_hit = first_set(isr, lowest);
  assign req_lvl = rank_to_lvl(req_hit[LVL_W-1:0], lowest);
  assign isr_top = rank_to_lvl(isr_hit[LVL_W-1:0], lowest);
  assign isr_any = isr_hit[LVL_W];
  assign int_ok  = ready && req_hit[LVL_W] &&
                   (!isr_hit[LVL_W] || (req_hit[LVL_W-1:0] < isr_hit[LVL_W-1:0]));

endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int NUM_IRQ = 8,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               int_out,
  input  logic               ack,
  output logic [DW-1:0]      ack_vector
);

  localparam int LVL_W  = $clog2(NUM_IRQ);
  localparam int BASE_W = DW - LVL_W;

  logic               wr_en, rd_en;
  logic               ready, level_mode, aeoi, read_isr, poll_armed;
  logic [NUM_IRQ-1:0] mask, irr, isr;
  logic [BASE_W-1:0]  vec_base;
  logic [LVL_W-1:0]   lowest, req_lvl, isr_top, eoi_lvl;
  logic               isr_any, int_ok, init_clr, eoi_clr;
  logic               poll_rd, svc;
  logic [DW-1:0]      poll_byte;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && bus_rd;
  assign poll_rd = rd_en && !bus_addr && poll_armed;
  assign svc     = (ack || poll_rd) && int_ok;

  irq_cmd_decode #(.NUM_IRQ(NUM_IRQ), .DW(DW), .LVL_W(LVL_W), .BASE_W(BASE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(bus_addr),
    .wdata(bus_wdata), .isr_any(isr_any), .isr_top(isr_top), .svc(svc),
    .svc_lvl(req_lvl), .ready(ready), .mask(mask), .vec_base(vec_base),
    .level_mode(level_mode), .aeoi(aeoi), .read_isr(read_isr),
    .poll_armed(poll_armed), .lowest(lowest), .init_clr(init_clr),
    .eoi_clr(eoi_clr), .eoi_lvl(eoi_lvl)
  );

  irq_req_reg #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .init_clr(init_clr), .svc(svc), .svc_lvl(req_lvl), .irr(irr)
  );

  irq_isr_reg #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .set_en(svc && !aeoi),
    .set_lvl(req_lvl), .clr_en(eoi_clr), .clr_lvl(eoi_lvl), .isr(isr)
  );

  irq_prio_resolve #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_res (
    .pend(irr & ~mask), .isr(isr), .lowest(lowest), .ready(ready),
    .req_lvl(req_lvl), .isr_any(isr_any), .isr_top(isr_top), .int_ok(int_ok)
  );

  always_comb begin
    poll_byte = '0;
    poll_byte[DW-1] = int_ok;
    if (int_ok) poll_byte[LVL_W-1:0] = req_lvl;
  end

  always_comb begin
    if (!rd_en)        bus_rdata = '0;
    else if (bus_addr) bus_rdata = DW'(mask);
    else if (poll_armed) bus_rdata = poll_byte;
    else if (read_isr) bus_rdata = DW'(isr);
    else               bus_rdata = DW'(irr);
  end

  assign int_out    = int_ok;
  assign ack_vector = {vec_base, int_ok ? req_lvl : {LVL_W{1'b1}}};

endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_out,
  input logic               ack,
  input logic [LVL_W-1:0]   ack_lvl,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               bus_addr,
  input logic [2:0]         cmd_bits,
  input logic               ready,
  input logic               aeoi,
  input logic               level_mode,
  input logic [NUM_IRQ-1:0] irr,
  input logic [NUM_IRQ-1:0] isr,
  input logic [NUM_IRQ-1:0] mask
);

  logic init_wr, eoi_wr, any_wr;
  assign any_wr  = bus_sel && bus_wr;
  assign init_wr = any_wr && !bus_addr && cmd_bits[1];
  assign eoi_wr  = any_wr && !bus_addr && cmd_bits[1:0] == 2'b00 && cmd_bits[2];

  p_init_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~mask) == '0) |-> !int_out);

  p_ack_clears_irr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !level_mode && !init_wr) |=> !irr[$past(ack_lvl)]);

  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi && !init_wr) |=> isr[$past(ack_lvl)]);

  p_eoi_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !ack && !bus_rd) |=> ($countones(isr) <= $past($countones(isr))));

  p_auto_keeps_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && aeoi && !any_wr) |=> (isr == $past(isr)));

endmodule

bind irq_ctrl8 irq_ctrl8_chk #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .ack(ack),
  .ack_lvl(ack_vector[LVL_W-1:0]), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .cmd_bits(bus_wdata[5:3]),
  .ready(ready), .aeoi(aeoi), .level_mode(level_mode), .irr(irr),
  .isr(isr), .mask(mask)
);

// File: tb/sim_irq_ctrl8.sv
`timescale 1ns/1ps
module sim_irq_ctrl8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, addr = 1'b0, wr_s = 1'b0, rd_s = 1'b0, ack = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] irq_in = '0;
  logic [7:0] bus_rdata, ack_vector;
  logic       int_out;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  irq_ctrl8 u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_addr(addr), .bus_wr(wr_s),
    .bus_rd(rd_s), .bus_wdata(wd), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .int_out(int_out), .ack(ack), .ack_vector(ack_vector)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr_s = 1; addr = a; wd = d;
    @(negedge clk); sel = 0; wr_s = 0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk); sel = 1; rd_s = 1; addr = a;
    #1 v = bus_rdata;
    @(negedge clk); sel = 0; rd_s = 0;
    check(tag, v, exp);
  endtask

  task automatic ack_chk(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk); ack = 1;
    #1 v = ack_vector;
    @(negedge clk); ack = 0;
    check(tag, v, exp);
  endtask

  task automatic int_chk(input string tag, input logic exp);
    #1 check(tag, {7'b0, int_out}, {7'b0, exp});
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic init(input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w4);
    irq_in = '0;
    wr(0, w1); wr(1, w2);
    if (!w1[1]) wr(1, 8'h00);
    if (w1[0])  wr(1, w4);
  endtask

  task automatic t_reset;
    int_chk("R1 int low after reset", 1'b0);
    rd_chk("R1 mask after reset", 1, 8'hFF);
    rd_chk("R1 request reg after reset", 0, 8'h00);
    ack_chk("R6 spurious ack vector", 8'h07);
    rd_chk("R6 spurious ack changes nothing", 0, 8'h00);
  endtask

  task automatic t_init_seq;
    irq_in = '0;
    wr(0, 8'h11);
    pulse(8'h04);
    int_chk("R2 int low during init", 1'b0);
    wr(1, 8'h48); wr(1, 8'h00);
    int_chk("R2 int low before last word", 1'b0);
    rd_chk("R2 mask cleared, words not in mask", 1, 8'h00);
    wr(1, 8'h00);
    int_chk("R2 int after init complete", 1'b1);
    ack_chk("R6 vector base 0x48 level 2", 8'h4A);
    wr(0, 8'h12); wr(1, 8'h30); wr(1, 8'h05);
    rd_chk("R2 short sequence then mask", 1, 8'h05);
    pulse(8'h02);
    ack_chk("R2 short sequence vector", 8'h31);
    wr(0, 8'h0B);
    rd_chk("R2 default options keep isr", 0, 8'h02);
  endtask

  task automatic t_mask_edge;
    init(8'h13, 8'h20, 8'h01);
    wr(1, 8'h04);
    pulse(8'h04);
    int_chk("R3 masked level no int", 1'b0);
    rd_chk("R4 edge latched after fall, R3 visible", 0, 8'h04);
    wr(1, 8'h00);
    int_chk("R3 unmask raises int", 1'b1);
    ack_chk("R6 vector level 2", 8'h22);
    int_chk("R6 int drops after ack", 1'b0);
    rd_chk("R6 request cleared by ack", 0, 8'h00);
    ack_chk("R6 spurious ack with isr busy", 8'h27);
    wr(0, 8'h0B);
    rd_chk("R6 spurious ack leaves isr", 0, 8'h04);
  endtask

  task automatic t_level;
    init(8'h1B, 8'h20, 8'h01);
    @(negedge clk); irq_in = 8'h20;
    rd_chk("R4 level request follows input", 0, 8'h20);
    int_chk("R4 level int", 1'b1);
    ack_chk("R6 level vector", 8'h25);
    int_chk("R5 same level in service blocks", 1'b0);
    wr(0, 8'h20);
    int_chk("R5 eoi re-allows held level", 1'b1);
    @(negedge clk); irq_in = 8'h00;
    rd_chk("R4 level request drops", 0, 8'h00);
    int_chk("R4 int drops with input", 1'b0);
  endtask

  task automatic t_nesting;
    init(8'h13, 8'h00, 8'h01);
    pulse(8'h10);
    ack_chk("R6 vector level 4", 8'h04);
    pulse(8'h40);
    int_chk("R5 lower level waits", 1'b0);
    pulse(8'h02);
    int_chk("R5 higher level nests", 1'b1);
    ack_chk("R6 nested vector", 8'h01);
    wr(0, 8'h0B);
    rd_chk("R10 select isr", 0, 8'h12);
    wr(0, 8'h20);
    rd_chk("R7 nonspecific clears top", 0, 8'h10);
    int_chk("R5 level 6 still below 4", 1'b0);
    wr(0, 8'h64);
    rd_chk("R7 specific clears level 4", 0, 8'h00);
    int_chk("R5 level 6 now served", 1'b1);
    ack_chk("R6 vector level 6", 8'h06);
    wr(0, 8'h08);
    rd_chk("R10 selection kept", 0, 8'h40);
    wr(0, 8'h0A);
    rd_chk("R10 select request reg", 0, 8'h00);
  endtask

  task automatic t_rotate;
    init(8'h13, 8'h00, 8'h01);
    wr(0, 8'hC3);
    pulse(8'h24);
    ack_chk("R8 set lowest 3 favours 5", 8'h05);
    wr(0, 8'hA0);
    int_chk("R8 rotate eoi freed", 1'b1);
    ack_chk("R8 next vector 2", 8'h02);
    pulse(8'h20);
    int_chk("R8 rotated level 5 now lowest", 1'b0);
    wr(0, 8'h40);
    wr(0, 8'h0B);
    rd_chk("R8 code 010 no effect", 0, 8'h04);
    wr(0, 8'hE2);
    int_chk("R8 rotate specific frees", 1'b1);
    ack_chk("R8 vector 5 after rotate", 8'h05);
    pulse(8'h0A);
    ack_chk("R8 lowest 2 favours 3 over 1", 8'h03);
  endtask

  task automatic t_aeoi;
    init(8'h13, 8'h80, 8'h03);
    wr(0, 8'h0B);
    pulse(8'h03);
    ack_chk("R9 auto vector 0", 8'h80);
    rd_chk("R9 isr not kept", 0, 8'h00);
    int_chk("R9 next level ready", 1'b1);
    wr(0, 8'h80);
    ack_chk("R9 vector 1", 8'h81);
    pulse(8'h09);
    ack_chk("R9 rotate in auto favours 3", 8'h83);
    wr(0, 8'h00);
    pulse(8'h10);
    ack_chk("R9 vector 4", 8'h84);
    pulse(8'h90);
    ack_chk("R9 rotation off keeps order", 8'h84);
  endtask

  task automatic t_poll;
    init(8'h13, 8'h10, 8'h01);
    pulse(8'h08);
    wr(0, 8'h0C);
    rd_chk("R11 poll byte level 3", 0, 8'h83);
    wr(0, 8'h0B);
    rd_chk("R11 poll set isr", 0, 8'h08);
    wr(0, 8'h0A);
    rd_chk("R11 poll cleared request", 0, 8'h00);
    wr(0, 8'h20);
    wr(1, 8'h40);
    pulse(8'h40);
    wr(0, 8'h0E);
    rd_chk("R11 poll nothing eligible", 0, 8'h00);
    rd_chk("R11 poll consumed by one read", 0, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_seq();
    t_mask_edge();
    t_level();
    t_nesting();
    t_rotate();
    t_aeoi();
    t_poll();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

endmodule